// File: doc/BRIEF.md
# Limited-Pointer Sharer Directory

This block keeps the coherence directory for a set of memory blocks. It does not give each block a bit for every processor. Instead, each block entry holds a small fixed number of processor-ID slots, and each slot has its own valid bit. The slots behave like a tiny fully associative store over the processor-ID space.

A read request records the requesting processor in a free slot. A write request sends an invalidation to every recorded sharer, and the writer then remains as the only holder.

When every slot is taken and a new processor asks for a copy, a per-request overflow policy decides the outcome. There are three choices:
- Evict an existing sharer in round-robin order.
- Mark the block for broadcast invalidation.
- Raise a trap so that software can extend the sharer set.

A build with zero slots traps on every request, which hands coherence entirely to software.

Invalidations leave the block as a processor bitmask, one cycle after the request. Transport of the messages and the software handler sit outside the block.

Top module: `ldir_directory`

## Requirements
- R1: After reset, every entry holds no sharers and no broadcast mark, `inv_valid` and `trap_valid` are low, and a write to any block produces no invalidation.
- R2: A read by a processor not yet recorded, with at least one free slot, stores that processor in the lowest-numbered free slot and produces neither invalidation nor trap.
- R3: A read by a processor already recorded in the entry changes nothing and produces neither invalidation nor trap.
- R4: Policy code 0 (evict), on a read that overflows a full entry: the slot chosen by the entry's round-robin counter is replaced by the requester. The counter starts at 0 after reset, advances by one after each eviction and wraps after the last slot. The displaced processor is the only bit set in `inv_mask`.
- R5: Policy code 1 (broadcast), on a read that overflows a full entry: the block's broadcast mark is set and nothing is sent. The next write to that block invalidates every processor except the writer.
- R6: Policy codes 2 and 3 (trap), on a read that overflows a full entry: `trap_valid` pulses for one cycle with the requester on `trap_proc` and the block on `trap_block`. The entry is left unchanged.
- R7: A write produces `inv_mask` with one bit per recorded sharer, never including the writer. Afterwards the entry holds only the writer, in slot 0, and its broadcast mark is cleared. The round-robin counter is unchanged.
- R8: Each block's entry evolves only under requests addressed to that block.
- R9: Outputs are registered and appear in the cycle after the request edge. `inv_valid` is high exactly when `inv_mask` is nonzero. A cycle without `req_valid` yields no invalidation and no trap.
- R10: With zero slots configured, every request, whether read or write, raises the trap and never an invalidation.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_block | input | BLK_W | Index of the memory block addressed |
| req_proc | input | PROC_W | Requesting processor ID |
| ovf_policy | input | 2 | Overflow policy: 0 evict, 1 broadcast, 2 or 3 trap |
| inv_valid | output | 1 | Invalidation bitmask is nonzero |
| inv_mask | output | 2**PROC_W | One bit per processor to invalidate |
| trap_valid | output | 1 | Software-extension trap pulse |
| trap_proc | output | PROC_W | Processor whose request trapped |
| trap_block | output | BLK_W | Block whose request trapped |

## Verification
An overflow eviction does two things in one cycle: it sends the invalidation to the victim and it installs the requester in the freed slot. Back-to-back requests to the same block also make a storage update and the following lookup meet at the same edge. Both cases are provoked by full-set read streams under the evict policy, and by a random stream confined to a few blocks and issued every cycle. A behavioural model in the bench predicts the mask, the trap and the later fan-out on every clock. Any mistake in the victim choice or in the slot reuse therefore shows up in a subsequent write mask.

// File: rtl/ldir_pkg.sv
package ldir_pkg;

    typedef enum logic [1:0] {
        OVF_EVICT = 2'd0,
        OVF_BCAST = 2'd1,
        OVF_TRAP  = 2'd2,
        OVF_TRAP2 = 2'd3
    } ovf_policy_e;

    function automatic logic policy_traps(input logic [1:0] pol);
        return pol[1];
    endfunction

    function automatic int slot_idx_w(input int slots);
        return (slots > 1) ? $clog2(slots) : 1;
    endfunction

endpackage

// File: rtl/ldir_entry_store.sv
module ldir_entry_store #(
    parameter int ENTRIES = 16,
    parameter int DATA_W  = 8,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data
);

    logic [DATA_W-1:0] mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem[rd_idx];

endmodule

// File: rtl/ldir_match.sv
module ldir_match #(
    parameter int SLOTS  = 4,
    parameter int PROC_W = 4,
    localparam int SI_W  = ldir_pkg::slot_idx_w(SLOTS)
) (
    input  logic [SLOTS-1:0][PROC_W-1:0] ptr,
    input  logic [SLOTS-1:0]             vld,
    input  logic [PROC_W-1:0]            proc,
    output logic                         hit,
    output logic                         full,
    output logic [SI_W-1:0]              free_slot
);

    logic [SLOTS-1:0] hit_vec;

    for (genvar s = 0; s < SLOTS; s++) begin : g_cmp
        assign hit_vec[s] = vld[s] && (ptr[s] == proc);
    end

    assign hit  = |hit_vec;
    assign full = &vld;

    always_comb begin
        free_slot = '0;
        for (int s = SLOTS - 1; s >= 0; s--) begin
            if (!vld[s]) free_slot = SI_W'(s);
        end
    end

endmodule

// File: rtl/ldir_fanout.sv
module ldir_fanout #(
    parameter int SLOTS  = 4,
    parameter int PROC_W = 4,
    localparam int NPROC = 1 << PROC_W
) (
    input  logic [SLOTS-1:0][PROC_W-1:0] ptr,
    input  logic [SLOTS-1:0]             vld,
    input  logic                         bcast,
    input  logic [PROC_W-1:0]            writer,
    output logic [NPROC-1:0]             mask
);

    logic [SLOTS-1:0][NPROC-1:0] slot_bits;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        always_comb begin
            slot_bits[s] = '0;
            if (vld[s]) slot_bits[s][ptr[s]] = 1'b1;
        end
    end

    always_comb begin
        logic [NPROC-1:0] acc;
        acc = bcast ? '1 : '0;
        for (int s = 0; s < SLOTS; s++) acc |= slot_bits[s];
        acc[writer] = 1'b0;
        mask = acc;
    end

endmodule

// File: rtl/ldir_directory.sv
module ldir_directory #(
    parameter int NUM_BLOCKS = 16,
    parameter int NUM_PTRS   = 4,
    parameter int PROC_W     = 4,
    localparam int BLK_W     = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
    localparam int NPROC     = 1 << PROC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [BLK_W-1:0]  req_block,
    input  logic [PROC_W-1:0] req_proc,
    input  logic [1:0]        ovf_policy,
    output logic              inv_valid,
    output logic [NPROC-1:0]  inv_mask,
    output logic              trap_valid,
    output logic [PROC_W-1:0] trap_proc,
    output logic [BLK_W-1:0]  trap_block
);
    import ldir_pkg::*;

    logic [NPROC-1:0] inv_n;
    logic             trap_n;

    if (NUM_PTRS == 0) begin : g_soft
        // Every request is handed to software.
        always_comb begin
            inv_n  = '0;
            trap_n = req_valid;
        end
    end else begin : g_hw
        localparam int SLOTS = NUM_PTRS;
        localparam int SI_W  = slot_idx_w(SLOTS);

        typedef struct packed {
            logic [SLOTS-1:0][PROC_W-1:0] ptr;
            logic [SLOTS-1:0]             vld;
            logic                         bcast;
            logic [SI_W-1:0]              rr;
        } entry_t;

        localparam int EW = $bits(entry_t);

        entry_t           cur, nxt;
        logic [EW-1:0]    rd_raw;
        logic             wr_en;
        logic             hit, full;
        logic [SI_W-1:0]  free_slot;
        logic [NPROC-1:0] wr_mask;
        logic [NPROC-1:0] victim_mask;
        logic [SI_W-1:0]  rr_next;

        ldir_entry_store #(.ENTRIES(NUM_BLOCKS), .DATA_W(EW)) u_store (
            .clk     (clk),
            .rst     (rst),
            .rd_idx  (req_block),
            .rd_data (rd_raw),
            .wr_en   (wr_en),
            .wr_idx  (req_block),
            .wr_data (nxt)
        );

        assign cur = entry_t'(rd_raw);

        ldir_match #(.SLOTS(SLOTS), .PROC_W(PROC_W)) u_match (
            .ptr       (cur.ptr),
            .vld       (cur.vld),
            .proc      (req_proc),
            .hit       (hit),
            .full      (full),
            .free_slot (free_slot)
        );

        ldir_fanout #(.SLOTS(SLOTS), .PROC_W(PROC_W)) u_fanout (
            .ptr    (cur.ptr),
            .vld    (cur.vld),
            .bcast  (cur.bcast),
            .writer (req_proc),
            .mask   (wr_mask)
        );

        always_comb begin
            victim_mask = '0;
            victim_mask[cur.ptr[cur.rr]] = 1'b1;
        end

        assign rr_next = (cur.rr == SI_W'(SLOTS - 1)) ? '0 : cur.rr + 1'b1;

        always_comb begin
            nxt    = cur;
            wr_en  = 1'b0;
            inv_n  = '0;
            trap_n = 1'b0;
            if (req_valid) begin
                if (req_write) begin
                    inv_n      = wr_mask;
                    nxt.ptr    = '0;
                    nxt.vld    = '0;
                    nxt.bcast  = 1'b0;
                    nxt.ptr[0] = req_proc;
                    nxt.vld[0] = 1'b1;
                    wr_en      = 1'b1;
                end else if (hit) begin
                    wr_en = 1'b0;
                end else if (!full) begin
                    nxt.ptr[free_slot] = req_proc;
                    nxt.vld[free_slot] = 1'b1;
                    wr_en              = 1'b1;
                end else if (policy_traps(ovf_policy)) begin
                    trap_n = 1'b1;
                end else if (ovf_policy == OVF_BCAST) begin
                    nxt.bcast = 1'b1;
                    wr_en     = 1'b1;
                end else begin
                    inv_n             = victim_mask;
                    nxt.ptr[cur.rr]   = req_proc;
                    nxt.rr            = rr_next;
                    wr_en             = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            inv_valid  <= 1'b0;
            inv_mask   <= '0;
            trap_valid <= 1'b0;
            trap_proc  <= '0;
            trap_block <= '0;
        end else begin
            inv_valid  <= |inv_n;
            inv_mask   <= inv_n;
            trap_valid <= trap_n;
            if (trap_n) begin
                trap_proc  <= req_proc;
                trap_block <= req_block;
            end
        end
    end

endmodule

// File: rtl/ldir_checker.sv
module ldir_checker #(
    parameter int NUM_PTRS = 4,
    parameter int PROC_W   = 4,
    parameter int BLK_W    = 4,
    localparam int NPROC   = 1 << PROC_W
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic [PROC_W-1:0] req_proc,
    input logic [1:0]        ovf_policy,
    input logic              inv_valid,
    input logic [NPROC-1:0]  inv_mask,
    input logic              trap_valid
);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!inv_valid && !trap_valid));

    // R4
    evict_single_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && ovf_policy == 2'd0) |=> ($countones(inv_mask) <= 1));

    // R7
    writer_spared_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write) |=> !inv_mask[$past(req_proc)]);

    // R5
    read_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && ovf_policy != 2'd0) |=> !inv_valid);

    // R6
    trap_excl_chk: assert property (@(posedge clk) disable iff (rst)
        trap_valid |-> !inv_valid);

    // R2
    no_hw_trap_chk: assert property (@(posedge clk) disable iff (rst)
        (NUM_PTRS != 0 && req_valid && (req_write || !ovf_policy[1])) |=> !trap_valid);

    // R10
    soft_trap_chk: assert property (@(posedge clk) disable iff (rst)
        (NUM_PTRS == 0 && req_valid) |=> trap_valid);

endmodule

bind ldir_directory ldir_checker #(
    .NUM_PTRS (NUM_PTRS),
    .PROC_W   (PROC_W),
    .BLK_W    (BLK_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_proc   (req_proc),
    .ovf_policy (ovf_policy),
    .inv_valid  (inv_valid),
    .inv_mask   (inv_mask),
    .trap_valid (trap_valid)
);

// File: tb/ldir_directory_test.sv
module ldir_directory_test;

    localparam int NB = 16;
    localparam int NP = 4;
    localparam int PW = 4;
    localparam int BW = 4;
    localparam int NPROC = 1 << PW;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req_valid = 1'b0;
    logic             req_write = 1'b0;
    logic [BW-1:0]    req_block = '0;
    logic [PW-1:0]    req_proc = '0;
    logic [1:0]       ovf_policy = '0;
    logic             inv_valid, inv_valid0;
    logic [NPROC-1:0] inv_mask, inv_mask0;
    logic             trap_valid, trap_valid0;
    logic [PW-1:0]    trap_proc, trap_proc0;
    logic [BW-1:0]    trap_block, trap_block0;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 0;

    always #10 clk = ~clk;

    ldir_directory #(.NUM_BLOCKS(NB), .NUM_PTRS(NP), .PROC_W(PW)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_block(req_block), .req_proc(req_proc), .ovf_policy(ovf_policy),
        .inv_valid(inv_valid), .inv_mask(inv_mask), .trap_valid(trap_valid),
        .trap_proc(trap_proc), .trap_block(trap_block)
    );

    ldir_directory #(.NUM_BLOCKS(NB), .NUM_PTRS(0), .PROC_W(PW)) uut0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_block(req_block), .req_proc(req_proc), .ovf_policy(ovf_policy),
        .inv_valid(inv_valid0), .inv_mask(inv_mask0), .trap_valid(trap_valid0),
        .trap_proc(trap_proc0), .trap_block(trap_block0)
    );

    // Behavioural model of the sharer records.
    int m_ptr [NB][NP];
    bit m_vld [NB][NP];
    bit m_bc  [NB];
    int m_rr  [NB];

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int b = 0; b < NB; b++) begin
            for (int s = 0; s < NP; s++) begin
                m_ptr[b][s] = 0;
                m_vld[b][s] = 0;
            end
            m_bc[b] = 0;
            m_rr[b] = 0;
        end
    endtask

    // One request cycle: drive at negedge, compare at the next negedge.
    task automatic step(input bit v, input bit w, input int blk, input int proc,
                        input int pol, input string tag);
        logic [NPROC-1:0] e_mask;
        bit e_trap;
        bit present;
        int freeslot;
        e_mask = '0;
        e_trap = 0;
        req_valid  = v;
        req_write  = w;
        req_block  = BW'(blk);
        req_proc   = PW'(proc);
        ovf_policy = 2'(pol);
        if (v) begin
            if (w) begin
                if (m_bc[blk]) e_mask = '1;
                for (int s = 0; s < NP; s++) if (m_vld[blk][s]) e_mask[m_ptr[blk][s]] = 1'b1;
                e_mask[proc] = 1'b0;
                for (int s = 0; s < NP; s++) begin
                    m_vld[blk][s] = 0;
                    m_ptr[blk][s] = 0;
                end
                m_ptr[blk][0] = proc;
                m_vld[blk][0] = 1;
                m_bc[blk] = 0;
            end else begin
                present = 0;
                freeslot = -1;
                for (int s = 0; s < NP; s++) begin
                    if (m_vld[blk][s] && m_ptr[blk][s] == proc) present = 1;
                    if (!m_vld[blk][s] && freeslot < 0) freeslot = s;
                end
                if (present) begin
                end else if (freeslot >= 0) begin
                    m_ptr[blk][freeslot] = proc;
                    m_vld[blk][freeslot] = 1;
                end else if (pol >= 2) begin
                    e_trap = 1;
                end else if (pol == 1) begin
                    m_bc[blk] = 1;
                end else begin
                    e_mask[m_ptr[blk][m_rr[blk]]] = 1'b1;
                    m_ptr[blk][m_rr[blk]] = proc;
                    m_rr[blk] = (m_rr[blk] + 1) % NP;
                end
            end
        end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(inv_mask == e_mask, tag, "inv_mask", inv_mask, e_mask);
        check(inv_valid == (e_mask != 0), tag, "inv_valid", inv_valid, e_mask != 0);
        check(trap_valid == e_trap, tag, "trap_valid", trap_valid, e_trap);
        if (e_trap) begin
            check(trap_proc == PW'(proc), tag, "trap_proc", trap_proc, proc);
            check(trap_block == BW'(blk), tag, "trap_block", trap_block, blk);
        end
        // R10: zero-slot instance traps on every request
        check(trap_valid0 == v, "R10", "trap_valid0", trap_valid0, v);
        check(!inv_valid0 && inv_mask0 == 0, "R10", "inv_mask0", inv_mask0, 0);
        if (v) check(trap_proc0 == PW'(proc), "R10", "trap_proc0", trap_proc0, proc);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            finish_run();
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check(!inv_valid && inv_mask == 0, "R1", "inv after reset", inv_mask, 0);
        check(!trap_valid, "R1", "trap after reset", trap_valid, 0);
        step(1, 1, 0, 1, 0, "R1");
        step(1, 1, 9, 3, 0, "R1");

        // R2 then R7
        step(1, 0, 1, 2, 0, "R2");
        step(1, 0, 1, 3, 0, "R2");
        step(1, 0, 1, 4, 0, "R2");
        step(1, 1, 1, 9, 0, "R7");
        step(1, 1, 1, 9, 0, "R7");

        // R3: duplicate reads
        step(1, 0, 2, 5, 0, "R3");
        step(1, 0, 2, 5, 0, "R3");
        step(1, 0, 2, 6, 0, "R3");
        step(1, 0, 2, 7, 0, "R3");
        step(1, 0, 2, 8, 0, "R3");
        step(1, 0, 2, 6, 0, "R3");
        step(1, 1, 2, 6, 0, "R7");

        // R4: round-robin eviction and wrap
        for (int p = 1; p <= 9; p++) step(1, 0, 3, p, 0, "R4");
        step(1, 1, 3, 0, 0, "R4");

        // R5: broadcast mark
        for (int p = 1; p <= 6; p++) step(1, 0, 4, p, 1, "R5");
        step(1, 1, 4, 2, 0, "R5");
        step(1, 1, 4, 3, 0, "R5");

        // R6: trap policy
        for (int p = 1; p <= 5; p++) step(1, 0, 5, p, 2, "R6");
        step(1, 0, 5, 11, 3, "R6");
        step(1, 1, 5, 0, 0, "R6");

        // R9: idle cycles
        for (int i = 0; i < 5; i++) step(0, 1, 4, 1, 0, "R9");

        // R8: mixed stream on a few blocks
        for (int i = 0; i < 4000; i++) begin
            step($urandom_range(9, 0) != 0, $urandom_range(5, 0) == 0,
                 int'($urandom_range(3, 0)), int'($urandom_range(NPROC - 1, 0)),
                 int'($urandom_range(3, 0)), "R8");
        end
        finish_run();
    end

endmodule